// File: doc/BRIEF.md
# Nibble-Wide Ethernet Frame Check Sequence Engine

This block computes the 32-bit Ethernet frame check sequence over a data stream that arrives four bits per clock, matching a media-independent-interface style datapath. Each byte is presented as two nibbles, the low nibble first. Each nibble advances a right-shifting register built on the reflected Ethernet generator 0xEDB88320. The register is preset to all ones at the start of every frame. The value to place on the wire is the bitwise complement of the register.

The same engine serves both directions. When transmitting, the sender feeds the payload and then sends the complemented register. It sends the least significant byte first, and each byte goes out low nibble first. When receiving, the checker feeds the payload followed by the received check bytes in the same order. A frame that arrived intact leaves a fixed residue in the register, and a flag reports it.

Top module: `eth_nib_crc`

## Requirements
- R1: While `rst` is high at a clock edge the register loads 0xFFFFFFFF, so `fcs` reads 0x00000000 and `fcs_ok` is low.
- R2: A cycle with `clr` high and `nib_vld` low loads 0xFFFFFFFF into the register at the next edge.
- R3: A cycle with `clr` and `nib_vld` both high starts a new frame that includes that nibble. The register becomes the one-nibble update of 0xFFFFFFFF, and the earlier contents are discarded.
- R4: In a cycle with `nib_vld` and `clr` both low, the register keeps its value.
- R5: A valid nibble applies four single-bit steps, taking bit 0 first. Each step XORs the data bit with register bit 0, shifts the register right by one, and XORs in 0xEDB88320 when that XOR was 1. Over the ASCII bytes "123456789" the resulting `fcs` is 0xCBF43926.
- R6: Bytes are fed low nibble first. For the 64-byte test frame (six 0xFF, six 0x11, tags 81 00 00 64 and 81 00 00 c8, then an ARP request), `fcs` ends at 0x876C005B. Sending it least significant byte first puts 5B 00 6C 87 on the wire.
- R7: `fcs` always equals the bitwise complement of `crc_q` in the same cycle.
- R8: After the frame and its four check bytes are fed, sent least significant byte first and each low nibble first, `crc_q` holds 0xDEBB20E3 and `fcs_ok` is high. If any data byte is corrupted, `fcs_ok` stays low.
- R9: `fcs_ok` is high exactly when `crc_q` equals 0xDEBB20E3, and it can only rise after a cycle with a valid nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Start-of-frame preset strobe |
| nib_vld | input | 1 | Nibble on `nib` is valid this cycle |
| nib | input | 4 | Data nibble, bit 0 earliest on the wire |
| crc_q | output | 32 | Running register |
| fcs | output | 32 | Complemented register, the check value to send |
| fcs_ok | output | 1 | Register holds the good-frame residue |

## Verification
The bench targets nibble and bit order first. The standard check string and the captured frame both produce values that any swap of nibbles, or a left-shifting update, would miss. It puts a preset in the same cycle as the first nibble, where an engine that ignored the preset would fold in the previous frame. It also puts idle gaps inside frames, where an engine that advanced without a valid strobe would drift. Finally it feeds the received check bytes back in, to show the residue is reached only when the check bytes arrive in wire order, and that a single corrupted byte keeps the good flag low.

// File: rtl/eth_nib_crc.sv
module eth_nib_crc #(
  parameter int          W       = 32,
  parameter logic [W-1:0] POLY    = 32'hEDB88320,
  parameter logic [W-1:0] RESIDUE = 32'hDEBB20E3,
  parameter int          NB      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          nib_vld,
  input  logic [NB-1:0] nib,
  output logic [W-1:0]  crc_q,
  output logic [W-1:0]  fcs,
  output logic          fcs_ok
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  function automatic logic [W-1:0] nib_step(input logic [W-1:0] c, input logic [NB-1:0] d);
    logic [W-1:0] r;
    r = c;
    for (int i = 0; i < NB; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? POLY : '0);
    return r;
  endfunction

  logic [W-1:0] base;
  assign base = clr ? ONES : crc_q;

  always_ff @(posedge clk) begin
    if (rst)           crc_q <= ONES;
    else if (nib_vld)  crc_q <= nib_step(base, nib);
    else if (clr)      crc_q <= ONES;
  end

  assign fcs    = ~crc_q;
  assign fcs_ok = (crc_q == RESIDUE);

  a_r1_reset_preset: assert property (@(posedge clk) $past(rst) |-> crc_q == ONES);
  a_r2_clear_preset: assert property (@(posedge clk) disable iff (rst)
    (clr && !nib_vld) |=> crc_q == ONES);
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !nib_vld) |=> $stable(crc_q));
  a_r9_ok_after_data: assert property (@(posedge clk) disable iff (rst)
    $rose(fcs_ok) |-> $past(nib_vld));
  a_r7_known_state: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(crc_q));
endmodule

// File: tb/sim_eth_nib_crc.sv
module sim_eth_nib_crc;
  logic clk = 0, rst = 1, clr = 0, nib_vld = 0;
  logic [3:0] nib = '0;
  logic [31:0] crc_q, fcs;
  logic fcs_ok;
  int checks = 0, errors = 0;
  logic [31:0] model = 32'hFFFFFFFF;
  int stepno = 0;

  eth_nib_crc u0 (.clk(clk), .rst(rst), .clr(clr), .nib_vld(nib_vld), .nib(nib),
                  .crc_q(crc_q), .fcs(fcs), .fcs_ok(fcs_ok));

  always #5 clk = ~clk;

  localparam logic [511:0] FRAME = {
    128'hffffffffffff111111111111_81000064,
    128'h810000c808060001080006040001_1111,
    128'h11111111c0a802010000000000000101,
    128'h01010000000000000000000000000000};

  function automatic logic [31:0] mbit(input logic [31:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    c = c >> 1;
    if (fb) c = c ^ 32'hEDB88320;
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic c, input logic v, input logic [3:0] n);
    logic [31:0] nxt;
    @(negedge clk);
    clr = c; nib_vld = v; nib = n;
    nxt = model;
    if (v) begin
      if (c) nxt = 32'hFFFFFFFF;
      for (int i = 0; i < 4; i++) nxt = mbit(nxt, n[i]);
    end else if (c) nxt = 32'hFFFFFFFF;
    @(posedge clk); #1;
    model = nxt;
    chk("R4/R5 register vs model", crc_q, model);
    chk("R7 complement", fcs, ~model);
    chk("R9 good flag", {31'b0, fcs_ok}, {31'b0, model == 32'hDEBB20E3});
  endtask

  task automatic send_byte(input logic [7:0] b, input logic first);
    stepno++;
    if (stepno % 7 == 0) step(1'b0, 1'b0, 4'hA);
    step(first, 1'b1, b[3:0]);
    step(1'b0, 1'b1, b[7:4]);
  endtask

  task automatic send_frame(input int corrupt);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] b;
      b = FRAME[511 - 8*i -: 8];
      if (i == corrupt) b = b ^ 8'h04;
      send_byte(b, i == 0);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) send_byte(w[8*k +: 8], 1'b0);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] tx;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset register", crc_q, 32'hFFFFFFFF);
    chk("R1 reset fcs", fcs, 32'h0);
    chk("R1 reset flag", {31'b0, fcs_ok}, 32'h0);
    @(negedge clk); rst = 0;

    step(1'b0, 1'b1, 4'h5);
    step(1'b0, 1'b1, 4'h3);
    send_frame(-1);
    chk("R6 frame fcs", fcs, 32'h876C005B);
    chk("R6 first wire byte", {24'b0, fcs[7:0]}, 32'h5B);
    chk("R6 last wire byte", {24'b0, fcs[31:24]}, 32'h87);
    tx = fcs;
    send_word(tx);
    chk("R8 residue", crc_q, 32'hDEBB20E3);
    chk("R8 good flag", {31'b0, fcs_ok}, 32'h1);
    step(1'b0, 1'b0, 4'h0);
    chk("R4 flag held on idle", {31'b0, fcs_ok}, 32'h1);

    step(1'b1, 1'b0, 4'h0);
    chk("R2 clear alone", crc_q, 32'hFFFFFFFF);

    step(1'b1, 1'b1, 4'h1);
    chk("R3 clear with nibble", crc_q, mbit(mbit(mbit(mbit(32'hFFFFFFFF,1),0),0),0));
    step(1'b0, 1'b1, 4'h3);
    for (int i = 1; i < 9; i++) send_byte(8'h30 + 8'(i + 1), 1'b0);
    chk("R5 check string", fcs, 32'hCBF43926);

    send_frame(20);
    send_word(32'h876C005B);
    chk("R8 corrupt frame flag", {31'b0, fcs_ok}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule